// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits between a simple host request port and a single-data-rate SDRAM with four banks and a 32-bit data bus. After reset it brings the memory up on its own. It first waits a fixed stable-clock delay with clock-enable raised. It then closes all banks, runs two refresh cycles and loads the mode register. From then on it accepts one request at a time and serves it as a closed-page access: it opens the row, then issues a read or write that precharges the row by itself. Refresh runs in the background.

A host offers a request by raising `req_valid` together with a flat address, write data and byte enables. The request is taken on the first clock edge where `req_ready` is also high. Read data comes back one cycle wide on `rd_valid`/`rd_data`. The read latency of the memory is either 2 or 3 clocks. It is chosen by the `cas_lat3` input, which is sampled only when the mode register is loaded. The controller captures read data at exactly that latency.

Top module: `sdram_seq`

## Requirements
- R1: While `rst` is high, the next cycle shows `sd_cke` low, `sd_cs_n` high (deselect), `rd_valid` low and `sd_dq_oe` low.
- R2: After reset, the command sequence is fixed. The first command is a precharge-all (address bit 10 high), issued `INIT_CYC` cycles after clock-enable is first sampled high. A refresh follows `T_RP` cycles later, and a second refresh `T_RFC` cycles after that. The mode-register load comes `T_RFC` cycles after the second refresh. No other command is issued before the first host request.
- R3: Every command other than NOP (CS,RAS,CAS,WE = 0,1,1,1) is issued only after `sd_cke` was already high in the previous cycle.
- R4: An accepted request issues activate on the next cycle. Activate carries bank = `req_addr[21:20]` on `sd_ba` and row = `req_addr[19:8]` on `sd_addr`. Exactly `T_RCD` cycles later it issues read (0,1,0,1) or write (0,1,0,0) to the same bank. That command carries column = `req_addr[7:0]` on `sd_addr[7:0]` and `sd_addr[10]` = 1, so the row precharges itself.
- R5: Write data is driven, with `sd_dq_oe` high, only in the write command cycle. In that cycle `sd_dqm` = ~`req_be`: a low `req_be` bit leaves the matching memory byte unchanged. `sd_dqm` is 0 during reads.
- R6: `rd_valid` is a single-cycle pulse carrying the memory word. It is high in the cycle that follows the controller's capture edge, which comes CL clock edges after the edge at which the memory sampled the read command.
- R7: After a read the next non-NOP command comes CL+`T_RP` cycles later; after a write it comes `T_WR`+`T_RP` cycles later. NOP is driven in between.
- R8: Refresh is issued every `CLK_MHZ*15625/1000` cycles, one row per 15.6 µs, so 4096 rows are covered in 64 ms. A refresh that falls due during an access is issued before the next host request is taken.
- R9: The mode register encodes CL in `sd_addr[6:4]` (010 = 2, 011 = 3), sequential order (`sd_addr[3]` = 0) and burst length 1 (`sd_addr[2:0]` = 000). `cas_lat3` is sampled only at that load; changing it later has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cas_lat3 | input | 1 | Read latency choice at mode load: 1 = 3 cycles, 0 = 2 cycles |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Request taken on this edge when valid is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | {bank[1:0], row[11:0], column[7:0]} |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables, bit i for byte i |
| rd_valid | output | 1 | Read data strobe, one cycle |
| rd_data | output | 32 | Read data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Multiplexed row/column/mode address |
| sd_dqm | output | 4 | Per-byte data mask |
| sd_dq_out | output | 32 | Data driven to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 32 | Data from memory |

## Verification
The checker watches several rules on every cycle. It checks the reset state and that clock-enable leads the first command. It checks that each accepted request turns into an activate, and that every column command carries the auto-precharge bit and is followed by a NOP. It also checks that the data bus is driven only on writes and that the read strobe lasts one cycle. Exact command gaps, the address split, the byte-mask merge, capture at the programmed latency and the order of the power-up sequence are checked by the bench. The bench uses a memory model that logs every command it samples. Refresh spacing, refresh winning over a steady stream of requests, and the latency choice being fixed at mode load can only be shown by the bench's longer scenarios.

// File: rtl/sdram_seq.sv
module sdram_seq #(
  parameter int CLK_MHZ  = 100,
  parameter int INIT_CYC = 20000,
  parameter int T_RCD    = 2,
  parameter int T_RP     = 2,
  parameter int T_RFC    = 7,
  parameter int T_WR     = 2,
  parameter int T_MRD    = 2,
  parameter int BA_W     = 2,
  parameter int ROW_W    = 12,
  parameter int COL_W    = 8,
  parameter int DQ_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cas_lat3,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_we,
  input  logic [BA_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]               req_wdata,
  input  logic [DQ_W/8-1:0]             req_be,
  output logic                          rd_valid,
  output logic [DQ_W-1:0]               rd_data,
  output logic                          sd_cke,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BA_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DQ_W/8-1:0]             sd_dqm,
  output logic [DQ_W-1:0]               sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DQ_W-1:0]               sd_dq_in
);
  localparam int AW      = BA_W + ROW_W + COL_W;
  localparam int BEW     = DQ_W / 8;
  localparam int REF_INT = CLK_MHZ * 15625 / 1000;
  localparam int WW      = $clog2(INIT_CYC + T_RFC + T_WR + T_RP + 8);
  localparam int RW      = $clog2(REF_INT + 1);

  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  typedef enum logic [2:0] {ST_PWR, ST_RF1, ST_RF2, ST_LMR, ST_IDLE, ST_COL} st_t;

  st_t              st;
  logic [3:0]       cmd;
  logic [WW-1:0]    wcnt;
  logic [RW-1:0]    rcnt;
  logic             ref_pend;
  logic             cl3_q;
  logic             we_q;
  logic [COL_W-1:0] col_q;
  logic [DQ_W-1:0]  wd_q;
  logic [BEW-1:0]   be_q;
  logic [2:0]       rpipe;
  logic             cap;
  logic             run;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign req_ready = (st == ST_IDLE) && (wcnt == '0) && !ref_pend;
  assign cap = cl3_q ? rpipe[2] : rpipe[1];
  assign run = (st == ST_IDLE) || (st == ST_COL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PWR;
      cmd       <= C_DES;
      wcnt      <= WW'(INIT_CYC);
      rcnt      <= RW'(REF_INT - 1);
      ref_pend  <= 1'b0;
      cl3_q     <= 1'b1;
      we_q      <= 1'b0;
      col_q     <= '0;
      wd_q      <= '0;
      be_q      <= '0;
      rpipe     <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      sd_cke    <= 1'b0;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dqm    <= '1;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
    end else begin
      sd_cke   <= 1'b1;
      cmd      <= C_NOP;
      sd_dq_oe <= 1'b0;
      sd_dqm   <= '0;
      rpipe    <= {rpipe[1:0], cmd == C_RD};
      rd_valid <= cap;
      if (cap) rd_data <= sd_dq_in;

      if (wcnt != '0) begin
        wcnt <= wcnt - 1'b1;
      end else begin
        case (st)
          ST_PWR: begin
            cmd     <= C_PRE;
            sd_ba   <= '0;
            sd_addr <= ROW_W'(1 << 10);
            wcnt    <= WW'(T_RP - 1);
            st      <= ST_RF1;
          end
          ST_RF1: begin
            cmd  <= C_REF;
            wcnt <= WW'(T_RFC - 1);
            st   <= ST_RF2;
          end
          ST_RF2: begin
            cmd  <= C_REF;
            wcnt <= WW'(T_RFC - 1);
            st   <= ST_LMR;
          end
          ST_LMR: begin
            cmd     <= C_MRS;
            sd_ba   <= '0;
            sd_addr <= ROW_W'({cas_lat3 ? 3'b011 : 3'b010, 4'b0000});
            cl3_q   <= cas_lat3;
            wcnt    <= WW'(T_MRD - 1);
            st      <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_pend) begin
              cmd      <= C_REF;
              ref_pend <= 1'b0;
              wcnt     <= WW'(T_RFC - 1);
            end else if (req_valid) begin
              cmd     <= C_ACT;
              sd_ba   <= req_addr[AW-1 -: BA_W];
              sd_addr <= req_addr[COL_W +: ROW_W];
              col_q   <= req_addr[COL_W-1:0];
              we_q    <= req_we;
              wd_q    <= req_wdata;
              be_q    <= req_be;
              wcnt    <= WW'(T_RCD - 1);
              st      <= ST_COL;
            end
          end
          ST_COL: begin
            cmd       <= we_q ? C_WR : C_RD;
            sd_addr   <= ROW_W'(col_q) | ROW_W'(1 << 10);
            sd_dq_oe  <= we_q;
            sd_dq_out <= wd_q;
            sd_dqm    <= we_q ? ~be_q : '0;
            wcnt      <= we_q ? WW'(T_WR + T_RP - 1)
                              : (cl3_q ? WW'(3 + T_RP - 1) : WW'(2 + T_RP - 1));
            st        <= ST_IDLE;
          end
          default: st <= ST_PWR;
        endcase
      end

      if (run) begin
        if (rcnt == '0) begin
          rcnt     <= RW'(REF_INT - 1);
          ref_pend <= 1'b1;
        end else begin
          rcnt <= rcnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rd_valid,
  input logic             sd_cke,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic             sd_dq_oe,
  input logic [ROW_W-1:0] sd_addr
);
  logic [3:0] c;
  assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (sd_cs_n && !sd_cke && !rd_valid && !sd_dq_oe));

  a_r3_cke_leads_cmd: assert property (@(posedge clk) disable iff (rst)
    (!sd_cs_n && c != 4'b0111) |-> $past(sd_cke));

  a_r4_accept_activates: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (c == 4'b0011));

  a_r4_col_autoprecharge: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0101 || c == 4'b0100) |-> sd_addr[10]);

  a_r5_oe_only_write: assert property (@(posedge clk) disable iff (rst)
    sd_dq_oe |-> (c == 4'b0100));

  a_r6_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r7_nop_after_col: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0101 || c == 4'b0100) |=> (c == 4'b0111));
endmodule

bind sdram_seq sdram_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dq_oe(sd_dq_oe), .sd_addr(sd_addr)
);

// File: tb/sim_sdram_seq.sv
`timescale 1ns/1ps
module sim_sdram_seq;
  localparam int CLKM = 200;
  localparam int INIT = 40;
  localparam int RCD  = 2;
  localparam int RP   = 2;
  localparam int RFC  = 7;
  localparam int TWR  = 2;
  localparam int MRD  = 2;
  localparam int REFI = CLKM * 15625 / 1000;
  localparam int LOGN = 8192;
  localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD = 4'b0101,
                         K_WR = 4'b0100, K_PRE = 4'b0010, K_REF = 4'b0001, K_MRS = 4'b0000;

  logic clk = 0, rst = 1, cas_lat3 = 1;
  logic req_valid = 0, req_we = 0;
  logic [21:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [31:0] rd_data, sd_dq_out, sd_dq_in;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;
  logic [3:0] sd_dqm;

  always #2.5 clk = ~clk;

  sdram_seq #(.CLK_MHZ(CLKM), .INIT_CYC(INIT), .T_RCD(RCD), .T_RP(RP), .T_RFC(RFC),
              .T_WR(TWR), .T_MRD(MRD)) u0 (
    .clk(clk), .rst(rst), .cas_lat3(cas_lat3), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in));

  int checks = 0, errors = 0;
  int cyc = 0;
  int rdn = 0, rdt = 0;
  logic [31:0] rdd = '0;

  logic [31:0] mem [logic [21:0]];
  logic [11:0] orow [4];
  logic [31:0] stg [3] = '{default: 32'h0};
  int mcl = 3;
  logic [3:0]  lc [LOGN];
  int          lt [LOGN];
  logic [1:0]  lb [LOGN];
  logic [11:0] la [LOGN];
  logic [3:0]  ld [LOGN];
  logic        loe [LOGN];
  logic [31:0] ldq [LOGN];
  int nlog = 0;
  int cke_rise = -1;

  assign sd_dq_in = stg[0];

  always @(posedge clk) begin
    logic [3:0] c;
    logic [21:0] k;
    logic [31:0] w;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    stg[0] <= stg[1];
    stg[1] <= stg[2];
    stg[2] <= 32'h0;
    if (!rst && sd_cke && cke_rise < 0) cke_rise = cyc;
    if (!rst && sd_cke && !sd_cs_n && c != K_NOP) begin
      if (nlog < LOGN) begin
        lc[nlog] = c; lt[nlog] = cyc; lb[nlog] = sd_ba; la[nlog] = sd_addr;
        ld[nlog] = sd_dqm; loe[nlog] = sd_dq_oe; ldq[nlog] = sd_dq_out;
        nlog++;
      end
      k = {sd_ba, orow[sd_ba], sd_addr[7:0]};
      case (c)
        K_ACT: orow[sd_ba] = sd_addr;
        K_RD: begin
          w = mem.exists(k) ? mem[k] : 32'hDEAD_BEEF;
          if (mcl == 2) stg[1] <= w; else stg[2] <= w;
        end
        K_WR: begin
          w = mem.exists(k) ? mem[k] : 32'hDEAD_BEEF;
          for (int b = 0; b < 4; b++) if (!sd_dqm[b]) w[8*b +: 8] = sd_dq_out[8*b +: 8];
          mem[k] = w;
        end
        K_MRS: mcl = int'(sd_addr[6:4]);
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rd_valid) begin rdn++; rdd = rd_data; rdt = cyc; end
    cyc++;
  end

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(100000 * 5);
    checks++; errors++;
    $display("FAIL watchdog (all R) actual=timeout expected=done");
    summary();
    $finish;
  end

  task automatic send(input bit we, input logic [21:0] a, input logic [31:0] d, input logic [3:0] be);
    req_we = we; req_addr = a; req_wdata = d; req_be = be; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_reset(input bit cl3);
    @(negedge clk);
    rst = 1; cas_lat3 = cl3; req_valid = 0;
    repeat (4) @(negedge clk);
    chk(!sd_cke && sd_cs_n && !rd_valid && !sd_dq_oe, "R1 reset outputs",
        {sd_cke, sd_cs_n, rd_valid, sd_dq_oe}, 4'b0100);
    nlog = 0; cke_rise = -1;
    rst = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_init(input int cl);
    chk(nlog == 4, "R2 init command count", nlog, 4);
    chk(lc[0] == K_PRE && la[0][10], "R2 precharge all first", {lc[0], la[0]}, {K_PRE, 12'h400});
    chk(lt[0] - cke_rise == INIT, "R3 cke lead before first command", lt[0] - cke_rise, INIT);
    chk(lc[1] == K_REF && lt[1] - lt[0] == RP, "R2 first refresh", lt[1] - lt[0], RP);
    chk(lc[2] == K_REF && lt[2] - lt[1] == RFC, "R2 second refresh", lt[2] - lt[1], RFC);
    chk(lc[3] == K_MRS && lt[3] - lt[2] == RFC, "R2 mode load timing", lt[3] - lt[2], RFC);
    chk(la[3][6:0] == {3'(cl), 4'b0000}, "R9 mode word", la[3][6:0], {3'(cl), 4'b0000});
  endtask

  task automatic access(input bit we, input logic [21:0] a, input logic [31:0] d,
                        input logic [3:0] be, input int cl, input logic [31:0] exp);
    int i0, n0, ia, ic;
    i0 = nlog; n0 = rdn;
    @(negedge clk);
    send(we, a, d, be);
    repeat (12) @(negedge clk);
    ia = -1;
    for (int i = i0; i < nlog; i++) if (ia < 0 && lc[i] == K_ACT) ia = i;
    if (ia < 0 || ia + 1 >= nlog) begin
      chk(0, "R4 activate and column command logged", nlog - i0, 2);
      return;
    end
    ic = ia + 1;
    chk(lb[ia] == a[21:20] && la[ia] == a[19:8], "R4 activate bank/row",
        {lb[ia], la[ia]}, a[21:8]);
    chk(lc[ic] == (we ? K_WR : K_RD) && lb[ic] == a[21:20] && la[ic][7:0] == a[7:0] && la[ic][10],
        "R4 column command", {lc[ic], lb[ic], la[ic]}, {(we ? K_WR : K_RD), a[21:20], 4'b0100, a[7:0]});
    chk(lt[ic] - lt[ia] == RCD, "R4 activate to column gap", lt[ic] - lt[ia], RCD);
    if (we) begin
      chk(loe[ic] && ld[ic] == ~be && ldq[ic] == d, "R5 write data and mask",
          {loe[ic], ld[ic], ldq[ic]}, {1'b1, ~be, d});
    end else begin
      chk(ld[ic] == 4'h0 && !loe[ic], "R5 read mask clear", {loe[ic], ld[ic]}, 0);
      chk(rdn == n0 + 1, "R6 one read strobe", rdn - n0, 1);
      chk(rdt - lt[ic] == cl, "R6 capture latency", rdt - lt[ic], cl);
      chk(rdd == exp, "R6 read data", rdd, exp);
    end
  endtask

  task automatic t_b2b(input bit we, input int cl);
    int i0, gap, ic, ia2;
    i0 = nlog;
    @(negedge clk);
    send(we, 22'h0A_5A5, 32'h1111_2222, 4'hF);
    send(we, 22'h1B_4C3, 32'h3333_4444, 4'hF);
    repeat (14) @(negedge clk);
    gap = we ? TWR + RP : cl + RP;
    ic = -1; ia2 = -1;
    for (int i = i0; i < nlog; i++) begin
      if (ic < 0 && (lc[i] == K_RD || lc[i] == K_WR)) ic = i;
      else if (ic >= 0 && ia2 < 0 && lc[i] == K_ACT) ia2 = i;
    end
    if (ic < 0 || ia2 < 0) chk(0, "R7 back-to-back commands logged", 0, 1);
    else chk(lt[ia2] - lt[ic] == gap, "R7 column to next activate gap", lt[ia2] - lt[ic], gap);
  endtask

  task automatic t_refresh_idle();
    int i0, r1, r2;
    i0 = nlog;
    repeat (2 * REFI + 100) @(negedge clk);
    r1 = -1; r2 = -1;
    for (int i = i0; i < nlog; i++) if (lc[i] == K_REF) begin
      if (r1 < 0) r1 = i; else if (r2 < 0) r2 = i;
    end
    chk(r1 >= 0 && r2 >= 0, "R8 refreshes while idle", (r1 >= 0) + (r2 >= 0), 2);
    if (r1 >= 0 && r2 >= 0) chk(lt[r2] - lt[r1] == REFI, "R8 refresh interval", lt[r2] - lt[r1], REFI);
  endtask

  task automatic t_refresh_busy(input int cl);
    int i0, nref, last, worst;
    i0 = nlog; nref = 0; last = -1; worst = 0;
    for (int i = 0; i < REFI / 8 + 80; i++) begin
      req_we = 0; req_addr = 22'(i * 37); req_be = 4'hF; req_valid = 1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
    end
    req_valid = 0;
    repeat (12) @(negedge clk);
    for (int i = i0; i < nlog; i++) if (lc[i] == K_REF) begin
      nref++;
      for (int j = i - 1; j >= 0; j--) if (lc[j] == K_REF) begin
        if (lt[i] - lt[j] > worst) worst = lt[i] - lt[j];
        break;
      end
      if (i + 1 < nlog && lt[i + 1] - lt[i] < RFC) last = i;
    end
    chk(nref >= 1, "R8 refresh taken under load", nref, 1);
    chk(worst <= REFI + RCD + cl + RP + 1, "R8 refresh delay bounded by one access",
        worst, REFI + RCD + cl + RP + 1);
    chk(last < 0, "R8 refresh recovery before next command", last, -1);
  endtask

  initial begin
    do_reset(1'b1);
    t_init(3);
    access(1, 22'h00_1234, 32'hCAFE_F00D, 4'hF, 3, 0);
    access(0, 22'h00_1234, 32'h0, 4'hF, 3, 32'hCAFE_F00D);
    access(1, 22'h3F_FFFF, 32'h0123_4567, 4'hF, 3, 0);
    access(0, 22'h3F_FFFF, 32'h0, 4'hF, 3, 32'h0123_4567);
    access(1, 22'h2A_B300, 32'h8899_AABB, 4'hF, 3, 0);
    access(1, 22'h2A_B300, 32'h1122_3344, 4'b0101, 3, 0);
    access(0, 22'h2A_B300, 32'h0, 4'hF, 3, 32'h8822_AA44);
    access(1, 22'h2A_B300, 32'hFFFF_FFFF, 4'b0000, 3, 0);
    access(0, 22'h2A_B300, 32'h0, 4'hF, 3, 32'h8822_AA44);
    t_b2b(0, 3);
    t_b2b(1, 3);
    cas_lat3 = 0;
    access(0, 22'h00_1234, 32'h0, 4'hF, 3, 32'hCAFE_F00D);
    t_refresh_idle();
    t_refresh_busy(3);
    do_reset(1'b0);
    t_init(2);
    access(0, 22'h3F_FFFF, 32'h0, 4'hF, 2, 32'h0123_4567);
    access(1, 22'h15_0001, 32'h5A5A_A5A5, 4'hF, 2, 0);
    access(0, 22'h15_0001, 32'h0, 4'hF, 2, 32'h5A5A_A5A5);
    t_b2b(0, 2);
    summary();
    $finish;
  end
endmodule